// File: doc/BRIEF.md
# Limit Counter Timer with Reached Flag

This block is a word-addressed counter/timer for a system bus. An up-counter advances by one step on each cycle in which the `tick` strobe is high. Software programs a limit. When the count would reach that limit, the counter returns to zero, a sticky reached flag is set and a level interrupt is raised. The interrupt stays high until software acknowledges it by reading the limit register. A limit of zero turns the block into a free-running counter that wraps at its maximum value and never signals.

The count field occupies the top data bits below bit 31, from bit 30 down to bit `CNT_LSB` (9 by default). Bit 31 of the counter word carries the reached flag, and the bits below `CNT_LSB` always read as zero. Three word offsets are decoded. Offset 0 is the limit register, and writing it restarts the count. Offset 1 is the counter, which can only be read. Offset 2 is a second write path to the limit that leaves the running count alone. An access is a single cycle with `bus_valid` high, and read data appears on `bus_rdata` one cycle later.

Top module: `lim_ctr_timer`

## Requirements
- R1: The count occupies data bits 30..CNT_LSB. Bits CNT_LSB-1..0 of every read word are zero. The count rises by exactly one unit on each cycle with `tick` high and holds on every cycle without it.
- R2: A read at word offset 1 returns {reached flag in bit 31, count in bits 30..CNT_LSB, zeros} as sampled in the request cycle, on `bus_rdata` in the following cycle.
- R3: With a nonzero limit L, the tick that would take the count to L instead sets it to 0, sets the reached flag and raises `irq`. `irq` then stays high through counter reads and through ticks until it is acknowledged.
- R4: A write at word offset 0 stores data bits 30..CNT_LSB as the limit, sets the count to 0 and drops `irq`. The reached flag keeps its value.
- R5: A read at word offset 0 returns the limit in bits 30..CNT_LSB with bit 31 and the low bits clear, and it clears both the reached flag and `irq`. If a limit hit occurs in that same cycle, the hit wins and both stay set.
- R6: A write at word offset 2 stores the limit but leaves the count, the reached flag and `irq` unchanged.
- R7: With a limit of zero the counter runs freely from its maximum value (all count bits set) back to 0, and it never sets the reached flag or raises `irq`.
- R8: A write at word offset 1 changes neither the count nor the limit.
- R9: Reads at word offsets 3 and above return zero, and writes there change no state.
- R10: After a synchronous active-low reset the limit, count, reached flag, `irq` and `bus_rdata` are all zero, and the counter runs on the next tick.
- R11: A write at offset 0 in the same cycle as a tick takes priority: the count becomes 0 and no hit is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request, one cycle per access |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| tick | input | 1 | Count-enable strobe |
| irq | output | 1 | Level interrupt on a limit hit |

## Verification
The checker verifies the following on every cycle: the low read bits are zero, the count holds without a tick, `irq` implies the reached flag, an `irq` rise never happens under a zero limit, and the effects of each offset's access on the count, limit, flag and interrupt. Other properties depend on the value of the limit and can only be shown by the bench's scenarios. These are the exact tick on which a hit occurs for every limit, the wrap point in free-run, the preserved reached flag after a limit write, and the priority when an acknowledge or a limit write falls on the same cycle as a tick. The bench therefore runs a reduced count width and sweeps every nonzero limit.

// File: rtl/lct_pkg.sv
// Shared constants and types for the limit counter timer.
// Assumes word offsets on the bus and a 32-bit data word.
package lct_pkg;
    localparam int DATA_W        = 32;
    localparam int OFS_LIMIT     = 0;  // limit, restarts count
    localparam int OFS_COUNT     = 1;  // counter, read only
    localparam int OFS_LIMIT_KEEP = 2; // limit, count untouched

    // Decoded single-cycle access
    typedef struct packed {
        logic wr_lim;
        logic wr_keep;
        logic rd_lim;
        logic rd_cnt;
    } lct_acc_t;
endpackage

// File: rtl/lct_decode.sv
// Turns a bus request into one-hot access strobes.
// Assumes at most one access per cycle; undefined offsets decode to nothing.
module lct_decode #(
    parameter int ADDR_W = 3
) (
    input  logic              valid_i,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    output lct_pkg::lct_acc_t acc_o
);
    import lct_pkg::*;

    // Offset compare and direction split
    always_comb begin
        acc_o         = '0;
        acc_o.wr_lim  = valid_i &&  write_i && (int'(addr_i) == OFS_LIMIT);
        acc_o.wr_keep = valid_i &&  write_i && (int'(addr_i) == OFS_LIMIT_KEEP);
        acc_o.rd_lim  = valid_i && !write_i && (int'(addr_i) == OFS_LIMIT);
        acc_o.rd_cnt  = valid_i && !write_i && (int'(addr_i) == OFS_COUNT);
    end
endmodule

// File: rtl/lct_limit_reg.sv
// Holds the programmed limit field and flags the free-run (zero) case.
// Assumes the caller has already extracted the field from the data word.
module lct_limit_reg #(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic [CNT_W-1:0] lim_o,
    output logic             free_o
);
    // Limit storage
    always_ff @(posedge clk) begin
        if (!rst_n)      lim_o <= '0;
        else if (load_i) lim_o <= val_i;
    end

    // Free-run indication
    assign free_o = (lim_o == '0);
endmodule

// File: rtl/lct_count_core.sv
// Up-counter with limit match, sticky reached flag and level interrupt.
// Assumes clr_i and ack_i are never high together (one access per cycle).
// A clear beats a tick; a hit beats an acknowledge.
module lct_count_core #(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             clr_i,
    input  logic             ack_i,
    input  logic [CNT_W-1:0] lim_i,
    input  logic             free_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             reached_o,
    output logic             irq_o,
    output logic             hit_o
);
    logic [CNT_W-1:0] cnt_inc;

    // Next count value, wrapping at the field width
    assign cnt_inc = cnt_o + 1'b1;

    // Limit match on a tick that is not overridden by a clear
    assign hit_o = tick_i && !clr_i && !free_i && (cnt_inc == lim_i);

    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_o <= '0;
        else if (clr_i)  cnt_o <= '0;
        else if (tick_i) cnt_o <= hit_o ? '0 : cnt_inc;
    end

    // Sticky reached flag, cleared only by acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)     reached_o <= 1'b0;
        else if (hit_o) reached_o <= 1'b1;
        else if (ack_i) reached_o <= 1'b0;
    end

    // Level interrupt, dropped by acknowledge or limit restart
    always_ff @(posedge clk) begin
        if (!rst_n)              irq_o <= 1'b0;
        else if (hit_o)          irq_o <= 1'b1;
        else if (ack_i || clr_i) irq_o <= 1'b0;
    end
endmodule

// File: rtl/lim_ctr_timer.sv
// Word-mapped limit counter timer: decode, limit register, count core
// and a registered read port. Assumes tick is a one-cycle-wide strobe
// synchronous to clk.
module lim_ctr_timer #(
    parameter int ADDR_W  = 3,
    parameter int CNT_LSB = 9
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_valid,
    input  logic                       bus_write,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [lct_pkg::DATA_W-1:0] bus_wdata,
    output logic [lct_pkg::DATA_W-1:0] bus_rdata,
    input  logic                       tick,
    output logic                       irq
);
    import lct_pkg::*;

    localparam int CNT_W = DATA_W - 1 - CNT_LSB;

    lct_acc_t         acc;
    logic [CNT_W-1:0] lim_q;
    logic [CNT_W-1:0] cnt_q;
    logic             free_run;
    logic             reached_q;
    logic             hit;

    lct_decode #(.ADDR_W(ADDR_W)) u_dec (
        .valid_i (bus_valid),
        .write_i (bus_write),
        .addr_i  (bus_addr),
        .acc_o   (acc)
    );

    lct_limit_reg #(.CNT_W(CNT_W)) u_lim (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (acc.wr_lim || acc.wr_keep),
        .val_i  (bus_wdata[DATA_W-2:CNT_LSB]),
        .lim_o  (lim_q),
        .free_o (free_run)
    );

    lct_count_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .clr_i     (acc.wr_lim),
        .ack_i     (acc.rd_lim),
        .lim_i     (lim_q),
        .free_i    (free_run),
        .cnt_o     (cnt_q),
        .reached_o (reached_q),
        .irq_o     (irq),
        .hit_o     (hit)
    );

    // Read data register, loaded one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (acc.rd_lim)
            bus_rdata <= {1'b0, lim_q, {CNT_LSB{1'b0}}};
        else if (acc.rd_cnt)
            bus_rdata <= {reached_q, cnt_q, {CNT_LSB{1'b0}}};
        else if (bus_valid && !bus_write)
            bus_rdata <= '0;
    end
endmodule

// File: rtl/lct_checker.sv
// Cycle properties of the limit counter timer, bound to the top module.
// Decodes the bus on its own rather than reusing the design's decoder.
module lct_checker #(
    parameter int ADDR_W  = 3,
    parameter int CNT_LSB = 9,
    parameter int CNT_W   = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              tick,
    input logic              irq,
    input logic [CNT_W-1:0]  lim_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              reached_q,
    input logic              hit
);
    logic w0, w1, w2, wx, r0, rx;

    // Independent access decode
    assign w0 = bus_valid &&  bus_write && (bus_addr == 0);
    assign w1 = bus_valid &&  bus_write && (bus_addr == 1);
    assign w2 = bus_valid &&  bus_write && (bus_addr == 2);
    assign wx = bus_valid &&  bus_write && (bus_addr > 2);
    assign r0 = bus_valid && !bus_write && (bus_addr == 0);
    assign rx = bus_valid && !bus_write && (bus_addr > 2);

    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[CNT_LSB-1:0] == '0);                                   // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !w0) |=> $stable(cnt_q));                              // R1
    AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> reached_q);                                              // R3
    AST_LIMIT_WR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        w0 |=> (cnt_q == '0 && !irq));                                   // R4
    AST_LIMIT_RD_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (r0 && !hit) |=> (!irq && !reached_q));                          // R5
    AST_KEEP_WR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (w2 && !tick) |=> $stable(cnt_q));                               // R6
    AST_FREE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(lim_q) != '0));                            // R7
    AST_CTR_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (w1 && !tick) |=> ($stable(cnt_q) && $stable(lim_q)));           // R8
    AST_UNDEF_WR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        wx |=> $stable(lim_q));                                          // R9
    AST_UNDEF_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rx |=> (bus_rdata == '0));                                       // R9
    AST_CLEAR_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (w0 && tick) |=> (cnt_q == '0 && !irq));                         // R11
endmodule

bind lim_ctr_timer lct_checker #(
    .ADDR_W  (ADDR_W),
    .CNT_LSB (CNT_LSB),
    .CNT_W   (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .tick      (tick),
    .irq       (irq),
    .lim_q     (lim_q),
    .cnt_q     (cnt_q),
    .reached_q (reached_q),
    .hit       (hit)
);

// File: tb/lim_ctr_timer_tb.sv
// Bench with a narrow count field (6 bits) so every limit and the wrap
// can be swept. Expected words are built arithmetically from the limits.
module lim_ctr_timer_tb;
    localparam int CLK_P   = 10;
    localparam int ADDR_W  = 3;
    localparam int CNT_LSB = 25;
    localparam int CNT_MAX = (1 << (31 - CNT_LSB)) - 1;
    localparam logic [31:0] UNIT  = 32'h1 << CNT_LSB;
    localparam logic [31:0] FLAG  = 32'h8000_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bv = 1'b0, bw = 1'b0, tk = 1'b0;
    logic [ADDR_W-1:0] ba = '0;
    logic [31:0]       bd = '0;
    logic [31:0]       rdata;
    logic              irq;
    logic [31:0]       rd;
    int                nchk = 0, nfail = 0;

    always #(CLK_P/2) clk = ~clk;

    lim_ctr_timer #(.ADDR_W(ADDR_W), .CNT_LSB(CNT_LSB)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bv), .bus_write(bw),
        .bus_addr(ba), .bus_wdata(bd), .bus_rdata(rdata), .tick(tk), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input int a, input logic [31:0] d);
        @(negedge clk); bv = 1'b1; bw = 1'b1; ba = ADDR_W'(a); bd = d;
        @(negedge clk); bv = 1'b0; bw = 1'b0;
    endtask

    task automatic bus_rd(input int a, output logic [31:0] d);
        @(negedge clk); bv = 1'b1; bw = 1'b0; ba = ADDR_W'(a);
        @(negedge clk); bv = 1'b0; d = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tk = 1'b1;
        end
        @(negedge clk); tk = 1'b0;
    endtask

    // Watchdog
    initial begin
        #(CLK_P * 200000);
        nfail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        chk("R10 irq", {31'b0, irq}, 32'h0);
        chk("R10 rdata", rdata, 32'h0);
        bus_rd(1, rd); chk("R10 count", rd, 32'h0);
        bus_rd(0, rd); chk("R10 limit", rd, 32'h0);

        // R1 R2 stepping and holding
        ticks(5);
        bus_rd(1, rd); chk("R1 five ticks", rd, 5 * UNIT);
        repeat (3) @(negedge clk);
        bus_rd(1, rd); chk("R1 hold", rd, 5 * UNIT);

        // R7 free-run wrap
        ticks(CNT_MAX - 5);
        bus_rd(1, rd); chk("R7 at max", rd, CNT_MAX * UNIT);
        chk("R7 no irq", {31'b0, irq}, 32'h0);
        ticks(1);
        bus_rd(1, rd); chk("R7 wrapped", rd, 32'h0);
        chk("R7 no irq after wrap", {31'b0, irq}, 32'h0);

        // R3 R4 R5 sweep of every nonzero limit
        for (int lim = 1; lim <= CNT_MAX; lim++) begin
            bus_wr(0, (lim * UNIT) | 32'h81FF_FFFF);
            ticks(lim - 1);
            chk("R3 before hit", {31'b0, irq}, 32'h0);
            bus_rd(1, rd); chk("R2 count before hit", rd, (lim - 1) * UNIT);
            ticks(1);
            chk("R3 irq on hit", {31'b0, irq}, 32'h1);
            bus_rd(1, rd); chk("R3 flag and zero count", rd, FLAG);
            chk("R3 irq held", {31'b0, irq}, 32'h1);
            bus_rd(0, rd); chk("R5 limit readback", rd, lim * UNIT);
            chk("R5 irq cleared", {31'b0, irq}, 32'h0);
            bus_rd(1, rd); chk("R5 flag cleared", rd, 32'h0);
        end

        // R4 limit write keeps the flag, drops irq
        bus_wr(0, 3 * UNIT);
        ticks(3);
        chk("R3 irq limit 3", {31'b0, irq}, 32'h1);
        bus_wr(0, 5 * UNIT);
        chk("R4 irq dropped", {31'b0, irq}, 32'h0);
        bus_rd(1, rd); chk("R4 flag kept count zero", rd, FLAG);
        bus_rd(0, rd); chk("R4 new limit", rd, 5 * UNIT);

        // R6 limit write without restart
        bus_wr(0, 10 * UNIT);
        ticks(4);
        bus_wr(2, 6 * UNIT);
        bus_rd(1, rd); chk("R6 count kept", rd, 4 * UNIT);
        bus_rd(0, rd); chk("R6 limit stored", rd, 6 * UNIT);
        ticks(2);
        chk("R6 hit at new limit", {31'b0, irq}, 32'h1);
        bus_wr(2, 9 * UNIT);
        chk("R6 irq untouched", {31'b0, irq}, 32'h1);
        bus_rd(1, rd); chk("R6 flag untouched", rd, FLAG);
        bus_rd(0, rd); chk("R6 limit updated", rd, 9 * UNIT);

        // R5 hit in the same cycle as acknowledge
        bus_wr(0, 2 * UNIT);
        ticks(1);
        @(negedge clk); bv = 1'b1; bw = 1'b0; ba = '0; tk = 1'b1;
        @(negedge clk); bv = 1'b0; tk = 1'b0; rd = rdata;
        chk("R5 read during hit", rd, 2 * UNIT);
        chk("R5 hit wins irq", {31'b0, irq}, 32'h1);
        bus_rd(1, rd); chk("R5 hit wins flag", rd, FLAG);
        bus_rd(0, rd);

        // R8 counter write ignored
        bus_wr(0, 32'h0);
        ticks(2);
        bus_wr(1, 32'hFFFF_FFFF);
        bus_rd(1, rd); chk("R8 count unchanged", rd, 2 * UNIT);
        bus_rd(0, rd); chk("R8 limit unchanged", rd, 32'h0);

        // R9 undefined offsets
        for (int a = 3; a < (1 << ADDR_W); a++) bus_wr(a, 32'hFFFF_FFFF);
        bus_rd(1, rd); chk("R9 count unchanged", rd, 2 * UNIT);
        bus_rd(0, rd); chk("R9 limit unchanged", rd, 32'h0);
        for (int a = 3; a < (1 << ADDR_W); a++) begin
            bus_rd(a, rd); chk("R9 read zero", rd, 32'h0);
        end

        // R11 limit write beats tick
        ticks(3);
        @(negedge clk); bv = 1'b1; bw = 1'b1; ba = '0; bd = 32'h0; tk = 1'b1;
        @(negedge clk); bv = 1'b0; bw = 1'b0; tk = 1'b0;
        bus_rd(1, rd); chk("R11 clear wins", rd, 32'h0);
        bus_wr(0, 1 * UNIT);
        @(negedge clk); bv = 1'b1; bw = 1'b1; ba = '0; bd = UNIT; tk = 1'b1;
        @(negedge clk); bv = 1'b0; bw = 1'b0; tk = 1'b0;
        chk("R11 no hit signalled", {31'b0, irq}, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule